// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block takes two 32-bit binary floating-point operands in the common single-precision layout and returns their packed product. Each packed word has a sign bit, an 8-bit biased exponent and a 23-bit fraction. The datapath works in four steps:

- The sign is the XOR of the two operand signs.
- The exponent is the sum of the biased exponent fields minus the bias.
- The two 24-bit significands, with their hidden ones restored, are multiplied into a 48-bit product.
- The product is normalised with at most one right shift, rounded to nearest with ties to even, and renormalised if the rounding carries out.

Operands are classified before the arithmetic. An exponent field of zero marks an operand as zero, so subnormal inputs are flushed. An all-ones exponent field marks infinity or NaN. A small set of result kinds (NaN, infinity, zero, normal, overflow, underflow) then picks what is packed. Overflow and underflow each raise their own flag.

A caller drives `in_valid` together with the two operands. By default the product, its flags and `out_valid` come from a single output register one cycle later. With `OUT_REG = 0` the block is purely combinational.

Top module: `fp32_mul`

## Requirements
- R1: For every result that is not NaN, sign bit 31 equals the XOR of the two operand sign bits, including zero and infinity results.
- R2: For two normal operands, the result exponent field is EA + EB - 127. If the 48-bit significand product is at least 2.0, the product is shifted right by one and the exponent is one higher.
- R3: Bits 22..0 keep the 23 fraction bits that follow the leading one. The round bit is the next lower bit, and the sticky bit is the OR of all bits below it. The kept value is incremented when round is 1 and either sticky or the kept LSB is 1, so an exact tie goes to the even neighbour.
- R4: When rounding carries out of all-ones fraction bits, the fraction becomes zero and the exponent rises by one.
- R5: If either operand is a NaN (exponent 255, fraction nonzero), or infinity is multiplied by zero, the result is the quiet NaN 0x7FC00000 and both flags are 0.
- R6: Infinity times a nonzero finite value or infinity gives a signed infinity (exponent 255, fraction 0). Zero times a finite value or zero gives a signed zero. Both flags are 0 in these cases.
- R7: An operand with exponent field 0 is treated as zero whatever its fraction bits hold.
- R8: If the exponent after rounding is 255 or more, the result is a signed infinity and `ovf_flag` is 1.
- R9: If the exponent after rounding is 0 or less, the result is a signed zero and `unf_flag` is 1. The two flags are never 1 together, and both are 0 for a result in the normal range.
- R10: With `OUT_REG = 1`:
  - `out_valid` follows `in_valid` by exactly one clock.
  - The product and flags are registered on a cycle with `in_valid` high.
  - Reset clears `out_valid`, `prod` and both flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are to be multiplied |
| op_a | input | 32 | First operand, packed single precision |
| op_b | input | 32 | Second operand, packed single precision |
| out_valid | output | 1 | `prod` and flags hold a new result |
| prod | output | 32 | Packed product |
| ovf_flag | output | 1 | Result exponent exceeded the finite range |
| unf_flag | output | 1 | Result exponent fell to zero or below |

## Verification
The bench aims at the edges of the rounding path:
- Exact ties on both an odd and an even kept LSB. A design that rounds half up would bump the even case.
- A truncation with only sticky bits set.
- A product whose rounding carries out of an all-ones fraction. A design that skips renormalisation would pack 1.0 with the old exponent, which is half the correct value.

It also multiplies operands at the exponent boundaries (2^127 times 2, the smallest normal times one half, the largest finite value times one). A design with too narrow an exponent sum would wrap these into small normal numbers instead of raising a flag.

The special operands cover the classification logic:
- NaN with any partner.
- Infinity times zero.
- Signed infinities.
- Subnormal operands that must act as zero.

A wrong ordering in that logic would return an infinity where a NaN is due, or a tiny value where zero is due.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    // What an operand's exponent and fraction fields make it
    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } opnd_cls_e;

    // What the packer is told to produce
    typedef enum logic [2:0] {
        RK_NAN,
        RK_INF,
        RK_ZERO,
        RK_NORMAL,
        RK_OVF,
        RK_UNF
    } res_kind_e;

endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] opnd,
    output opnd_cls_e             cls,
    output logic                  sgn,
    output logic [EXP_W-1:0]      expo,
    output logic [FRAC_W:0]       sig
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [FRAC_W-1:0] frac;

    assign sgn  = opnd[W-1];
    assign expo = opnd[W-2 -: EXP_W];
    assign frac = opnd[FRAC_W-1:0];
    // hidden one restored; meaningless for non-normal classes
    assign sig  = {1'b1, frac};

    always_comb begin
        if (expo == '0) begin
            cls = CLS_ZERO;            // subnormals flushed here (R7)
        end else if (expo == '1) begin
            cls = (frac == '0) ? CLS_INF : CLS_NAN;
        end else begin
            cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/fpm_sig_round.sv
module fpm_sig_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [FRAC_W:0]          sig_a,
    input  logic [FRAC_W:0]          sig_b,
    input  logic [EXP_W-1:0]         exp_a,
    input  logic [EXP_W-1:0]         exp_b,
    output logic [FRAC_W-1:0]        frac_out,
    output logic signed [EXP_W+1:0]  exp_out
);
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XW     = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int KEEP_H = PROD_W - 3;          // top kept fraction bit
    localparam int RND_B  = KEEP_H - FRAC_W;     // round bit position
    localparam int STK_H  = RND_B - 1;           // top sticky bit

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] norm;
    logic              hi;
    logic [FRAC_W-1:0] kept;
    logic              rbit;
    logic              sticky;
    logic              inc;
    logic [FRAC_W:0]   rsum;
    logic              carry;

    assign prod = PROD_W'(sig_a) * PROD_W'(sig_b);
    assign hi   = prod[PROD_W-1];             // product in [2,4)  (R2)
    assign norm = hi ? (prod >> 1) : prod;

    assign kept   = norm[KEEP_H -: FRAC_W];
    assign rbit   = norm[RND_B];
    assign sticky = (|norm[STK_H:0]) | (hi & prod[0]);

    // nearest, ties to even  (R3)
    assign inc   = rbit & (sticky | kept[0]);
    assign rsum  = {1'b0, kept} + (FRAC_W+1)'(inc);
    assign carry = rsum[FRAC_W];              // renormalise  (R4)

    assign frac_out = rsum[FRAC_W-1:0];
    assign exp_out  = $signed(XW'(exp_a) + XW'(exp_b) + XW'(hi) + XW'(carry)
                              - XW'(BIAS));

endmodule

// File: rtl/fp32_mul.sv
module fp32_mul
    import fpm_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] prod,
    output logic                  ovf_flag,
    output logic                  unf_flag
);
    localparam int W    = 1 + EXP_W + FRAC_W;
    localparam int XW   = EXP_W + 2;
    localparam int EMAX = (1 << EXP_W) - 1;
    localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    opnd_cls_e          cls_a, cls_b;
    logic               sign_a, sign_b, res_sign;
    logic [EXP_W-1:0]   exp_a, exp_b;
    logic [FRAC_W:0]    sig_a, sig_b;
    logic [FRAC_W-1:0]  frac_r;
    logic signed [XW-1:0] exp_r;
    res_kind_e          kind;
    logic [W-1:0]       nxt_prod;
    logic               nxt_ovf, nxt_unf;

    fpm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
        .opnd(op_a), .cls(cls_a), .sgn(sign_a), .expo(exp_a), .sig(sig_a)
    );

    fpm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
        .opnd(op_b), .cls(cls_b), .sgn(sign_b), .expo(exp_b), .sig(sig_b)
    );

    fpm_sig_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .sig_a(sig_a), .sig_b(sig_b), .exp_a(exp_a), .exp_b(exp_b),
        .frac_out(frac_r), .exp_out(exp_r)
    );

    assign res_sign = sign_a ^ sign_b;        // (R1)

    // result kind: NaN first, then infinity, then zero, then range
    always_comb begin
        if (cls_a == CLS_NAN || cls_b == CLS_NAN) begin
            kind = RK_NAN;                                   // (R5)
        end else if (cls_a == CLS_INF || cls_b == CLS_INF) begin
            kind = (cls_a == CLS_ZERO || cls_b == CLS_ZERO) ? RK_NAN : RK_INF;
        end else if (cls_a == CLS_ZERO || cls_b == CLS_ZERO) begin
            kind = RK_ZERO;                                  // (R6, R7)
        end else if (exp_r >= $signed(XW'(EMAX))) begin
            kind = RK_OVF;                                   // (R8)
        end else if (exp_r <= $signed(XW'(0))) begin
            kind = RK_UNF;                                   // (R9)
        end else begin
            kind = RK_NORMAL;
        end
    end

    // packer
    always_comb begin
        nxt_ovf = 1'b0;
        nxt_unf = 1'b0;
        unique case (kind)
            RK_NAN:    nxt_prod = QNAN;
            RK_INF:    nxt_prod = {res_sign, INF_MAG};
            RK_ZERO:   nxt_prod = {res_sign, {(W-1){1'b0}}};
            RK_OVF: begin
                nxt_prod = {res_sign, INF_MAG};
                nxt_ovf  = 1'b1;
            end
            RK_UNF: begin
                nxt_prod = {res_sign, {(W-1){1'b0}}};
                nxt_unf  = 1'b1;
            end
            RK_NORMAL: nxt_prod = {res_sign, exp_r[EXP_W-1:0], frac_r};
            default:   nxt_prod = QNAN;
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_valid <= 1'b0;
                    prod      <= '0;
                    ovf_flag  <= 1'b0;
                    unf_flag  <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        prod     <= nxt_prod;
                        ovf_flag <= nxt_ovf;
                        unf_flag <= nxt_unf;
                    end
                end
            end

            assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            assert_sign_xor_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && kind != RK_NAN) |=> prod[W-1] == $past(op_a[W-1] ^ op_b[W-1]));
        end else begin : g_comb
            assign out_valid = in_valid;
            assign prod      = nxt_prod;
            assign ovf_flag  = nxt_ovf;
            assign unf_flag  = nxt_unf;
        end
    endgenerate

    assert_ovf_inf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf_flag) |-> prod[W-2:0] == INF_MAG);
    assert_unf_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && unf_flag) |-> prod[W-2:0] == '0);
    assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && unf_flag));
    assert_nan_canon_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && prod[W-2 -: EXP_W] == '1 && prod[FRAC_W-1:0] != '0)
            |-> (prod == QNAN && !ovf_flag && !unf_flag));

endmodule

// File: tb/fp32_mul_tb.sv
`timescale 1ns/1ps
module fp32_mul_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] op_a, op_b;
    logic        out_valid;
    logic [31:0] prod;
    logic        ovf_flag, unf_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [33:0] exp_q[$];
    string       tag_q[$];
    bit          pend_v = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    fp32_mul u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .prod(prod),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    // behavioural reference: returns {ovf, unf, packed}
    function automatic logic [33:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic              s;
        int                ea, eb, e;
        bit                a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
        longint unsigned   p;
        bit                rb, sb;
        s      = a[31] ^ b[31];
        ea     = int'(a[30:23]);
        eb     = int'(b[30:23]);
        a_zero = (ea == 0);
        b_zero = (eb == 0);
        a_inf  = (ea == 255) && (a[22:0] == 0);
        b_inf  = (eb == 255) && (b[22:0] == 0);
        a_nan  = (ea == 255) && (a[22:0] != 0);
        b_nan  = (eb == 255) && (b[22:0] != 0);
        if (a_nan || b_nan) return {2'b00, 32'h7FC0_0000};
        if (a_inf || b_inf) begin
            if (a_zero || b_zero) return {2'b00, 32'h7FC0_0000};
            return {2'b00, s, 8'hFF, 23'd0};
        end
        if (a_zero || b_zero) return {2'b00, s, 31'd0};
        p  = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
        rb = 1'b0;
        sb = 1'b0;
        e  = ea + eb - 127 - 23;
        while (p >= 64'd16777216) begin
            sb = sb | rb;
            rb = p[0];
            p  = p >> 1;
            e  = e + 1;
        end
        if (rb && (sb || p[0])) p = p + 1;
        if (p == 64'd16777216) begin
            p = p >> 1;
            e = e + 1;
        end
        if (e >= 255) return {2'b10, s, 8'hFF, 23'd0};
        if (e <= 0)   return {2'b01, s, 31'd0};
        return {2'b00, s, e[7:0], p[22:0]};
    endfunction

    task automatic step(input bit v, input logic [31:0] x, input logic [31:0] y, input string tag);
        logic [33:0] want;
        string       t;
        @(negedge clk);
        checks++;
        if (out_valid !== pend_v) begin
            errors++;
            $display("FAIL R10 out_valid: got %b expected %b", out_valid, pend_v);
        end
        if (pend_v) begin
            want = exp_q.pop_front();
            t    = tag_q.pop_front();
            checks++;
            if ({ovf_flag, unf_flag, prod} !== want) begin
                errors++;
                $display("FAIL %s: got prod=%h ovf=%b unf=%b expected prod=%h ovf=%b unf=%b",
                         t, prod, ovf_flag, unf_flag, want[31:0], want[33], want[32]);
            end
        end
        in_valid = v;
        op_a     = x;
        op_b     = y;
        pend_v   = v;
        if (v) begin
            exp_q.push_back(ref_mul(x, y));
            tag_q.push_back(tag);
        end
    endtask

    function automatic logic [31:0] rnd_normal();
        logic [7:0] e;
        e = 8'($urandom_range(190, 64));
        return {1'($urandom_range(1, 0)), e, 23'($urandom())};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        op_a     = '0;
        op_b     = '0;
        repeat (3) @(negedge clk);
        checks++;
        if ({out_valid, prod, ovf_flag, unf_flag} !== 35'd0) begin
            errors++;
            $display("FAIL R10 reset: got valid=%b prod=%h ovf=%b unf=%b expected all zero",
                     out_valid, prod, ovf_flag, unf_flag);
        end
        rst_n = 1'b1;
        step(0, 32'h0, 32'h0, "R10 idle");

        // R2 exponent and normalisation
        step(1, 32'h3F80_0000, 32'h3F80_0000, "R2 one times one");
        step(1, 32'h3FC0_0000, 32'h3FC0_0000, "R2 product above two");
        step(1, 32'hBDE8_40A1, 32'h3EC0_1000, "R2 R3 negative mixed");
        // R1 signs
        step(1, 32'hC000_0000, 32'hC040_0000, "R1 neg times neg");
        step(1, 32'h4000_0000, 32'hC040_0000, "R1 pos times neg");
        // R3 rounding: tie odd up, tie even down, sticky only truncates
        step(1, 32'h3F80_0001, 32'h3FC0_0000, "R3 tie odd");
        step(1, 32'h3F80_0003, 32'h3FC0_0000, "R3 tie even");
        step(1, 32'h3F80_0001, 32'h3F80_0001, "R3 sticky only");
        // R4 rounding carry: 0x3FFFFFFA * 0x3F800003 -> 2.0
        step(1, 32'h3FFF_FFFA, 32'h3F80_0003, "R4 rounding carry");
        // gap: in_valid low
        step(0, 32'h1234_5678, 32'h9ABC_DEF0, "R10 gap");
        // R5 NaN cases
        step(1, 32'h7FC0_0000, 32'h3F80_0000, "R5 nan operand");
        step(1, 32'h4000_0000, 32'hFF80_0001, "R5 signalling nan");
        step(1, 32'h7F80_0000, 32'h0000_0000, "R5 inf times zero");
        step(1, 32'h8000_0000, 32'hFF80_0000, "R5 zero times neg inf");
        // R6 infinities and zeros
        step(1, 32'h7F80_0000, 32'hC000_0000, "R6 inf times neg");
        step(1, 32'hFF80_0000, 32'hFF80_0000, "R6 inf times inf");
        step(1, 32'h8000_0000, 32'h4040_0000, "R6 neg zero");
        // R7 subnormal flush
        step(1, 32'h0000_0001, 32'h3F80_0000, "R7 subnormal");
        step(1, 32'h807F_FFFF, 32'h7F00_0000, "R7 neg subnormal");
        // R8 overflow
        step(1, 32'h7F00_0000, 32'h4000_0000, "R8 overflow");
        step(1, 32'hFF7F_FFFF, 32'h7F7F_FFFF, "R8 neg overflow");
        step(1, 32'h7F7F_FFFF, 32'h3F80_0000, "R8 largest stays");
        // R9 underflow
        step(1, 32'h0080_0000, 32'h3F00_0000, "R9 underflow");
        step(1, 32'h8080_0000, 32'h0080_0000, "R9 neg underflow");
        step(1, 32'h0080_0000, 32'h3F80_0000, "R9 smallest stays");

        for (int i = 0; i < 1500; i++) begin
            step(1, rnd_normal(), rnd_normal(), "R2 R3 random normal");
        end
        for (int i = 0; i < 500; i++) begin
            step(i % 7 != 0, $urandom(), $urandom(), "R8 R9 random any");
        end
        step(0, 32'h0, 32'h0, "R10 flush");
        step(0, 32'h0, 32'h0, "R10 idle end");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule